// File: doc/BRIEF.md
# Low-Power Clock Handshake, Peripheral Side

This block sits in a peripheral and talks to a system clock controller over a three-wire handshake. It drives a clock-need flag that tells the controller whether the peripheral currently needs its clock. A request line from the controller sits high during normal operation; pulling it low asks the peripheral to enter a low-power state. The peripheral answers on an acknowledge line that also rests high. It lowers the acknowledge to answer a request, and raises it again to close a handshake. A separate flag shows whether the low-power state is in force.

When a request arrives and the local busy input is low, the peripheral accepts. It drops the acknowledge and the clock-need flag together and enters the low-power state. When busy is high, the peripheral denies. It still drops the acknowledge but keeps the clock-need flag high. It then waits for the controller to raise the request line before raising the acknowledge again.

The low-power state can end in two ways:
- Controller-initiated: the controller raises the request line. The peripheral accepts by raising the clock-need flag, and one cycle later signals completion by raising the acknowledge.
- Peripheral-initiated: a local wake or busy indication raises the clock-need flag. The controller grants this by raising the request line, and the peripheral then completes with the acknowledge high.

The request line is passed through a parameterised synchroniser before its edges are detected.

Top module: `lp_handshake_periph`

## Requirements
- R1: While reset is high and on the first edge after it, the acknowledge is 1, the low-power flag is 0 and the clock-need flag is 0.
- R2: In the run state, the clock-need flag equals the busy input as sampled one clock edge earlier.
- R3: Suppose the request line falls while busy is 0. Exactly SYNC_STAGES+1 edges later, the acknowledge and the clock-need flag both become 0 and the low-power flag becomes 1.
- R4: Suppose the request line falls while busy is 1. The request is denied: SYNC_STAGES+1 edges later the acknowledge becomes 0, the clock-need flag stays 1 and the low-power flag stays 0.
- R5: After a denial, a rise of the request line raises the acknowledge exactly SYNC_STAGES+1 edges later, and the block returns to the run state.
- R6: When the request line rises in the low-power state, exit is controller-initiated. The clock-need flag becomes 1 exactly SYNC_STAGES+1 edges later. One edge after that, the acknowledge becomes 1 and the low-power flag becomes 0.
- R7: In the low-power state, wake or busy at 1 raises the clock-need flag one edge later. This starts a peripheral-initiated exit. The acknowledge stays 0 and the low-power flag stays 1 until the request line rises. Exactly SYNC_STAGES+1 edges after that rise, the acknowledge becomes 1 and the low-power flag becomes 0.
- R8: The acknowledge changes only in answer to a synchronised edge of the request line. It never changes earlier than SYNC_STAGES+1 edges after the request line moves.
- R9: In the run state, the wake input has no effect: the clock-need flag follows busy alone.
- R10: While the block is in the low-power state with busy and wake at 0 and the request line low, the acknowledge and the clock-need flag stay 0 and the low-power flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_run_req | input | 1 | Controller request line; low asks for low power, high asks for run |
| busy_i | input | 1 | Local busy indication |
| wake_i | input | 1 | Local wake request |
| need_clk_o | output | 1 | Peripheral needs its clock |
| periph_ack_o | output | 1 | Handshake acknowledge; rests high |
| lp_state_o | output | 1 | Low-power state in force |

## Verification
Every handshake answer to a move of the request line is due exactly SYNC_STAGES+1 edges after that move. The one exception is the completion step of a controller-initiated exit, which follows one edge later. Local busy and wake effects are due one edge after the change. The bench changes inputs just after a rising edge and first samples one edge before the due edge, expecting the old value there. It then samples just after the due edge, so both an early answer and a late answer are caught. The sweep covers accept and deny for each busy level, each of the three exit routes, and wake activity in the run state.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [2:0] {
    LP_RUN  = 3'd0,
    LP_DENY = 3'd1,
    LP_LOW  = 3'd2,
    LP_EXIT = 3'd3,
    LP_WAKE = 3'd4
  } lp_state_e;
endpackage

// File: rtl/lp_req_sync.sv
module lp_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain;
  logic              prev;
  logic              synced;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= req_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], req_i};
      end
    end
  endgenerate

  assign synced = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= synced;
  end

  assign fall_o = prev & ~synced;
  assign rise_o = ~prev & synced;
endmodule

// File: rtl/lp_hs_fsm.sv
module lp_hs_fsm
  import lp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fall_i,
  input  logic rise_i,
  input  logic busy_i,
  input  logic wake_i,
  output logic need_clk_o,
  output logic ack_o,
  output logic lp_o
);
  lp_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= LP_RUN;
      ack_o      <= 1'b1;
      need_clk_o <= 1'b0;
      lp_o       <= 1'b0;
    end else begin
      case (st)
        LP_RUN: begin
          need_clk_o <= busy_i;
          if (fall_i) begin
            ack_o <= 1'b0;
            if (busy_i) begin
              need_clk_o <= 1'b1;
              st         <= LP_DENY;
            end else begin
              need_clk_o <= 1'b0;
              lp_o       <= 1'b1;
              st         <= LP_LOW;
            end
          end
        end
        LP_DENY: begin
          need_clk_o <= 1'b1;
          if (rise_i) begin
            ack_o <= 1'b1;
            st    <= LP_RUN;
          end
        end
        LP_LOW: begin
          if (rise_i) begin
            need_clk_o <= 1'b1;
            st         <= LP_EXIT;
          end else if (wake_i || busy_i) begin
            need_clk_o <= 1'b1;
            st         <= LP_WAKE;
          end
        end
        LP_EXIT: begin
          ack_o <= 1'b1;
          lp_o  <= 1'b0;
          st    <= LP_RUN;
        end
        LP_WAKE: begin
          if (rise_i) begin
            ack_o <= 1'b1;
            lp_o  <= 1'b0;
            st    <= LP_RUN;
          end
        end
        default: st <= LP_RUN;
      endcase
    end
  end

  // R8: acknowledge falls only after a synchronised falling request
  assert_ack_fall_on_edge_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_o) |-> $past(fall_i));

  // R8: acknowledge rises only one or two edges after a synchronised rise
  assert_ack_rise_on_edge_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> ($past(rise_i) || $past(rise_i, 2)));

  // R3: entering low power drops both the clock need and the acknowledge
  assert_low_entry_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(lp_o) |-> (!need_clk_o && !ack_o));

  // R4: an open handshake outside low power means a denial, clock kept
  assert_deny_keeps_clock_R4: assert property (@(posedge clk) disable iff (rst)
    (!ack_o && !lp_o) |-> need_clk_o);

  // R6: leaving low power happens with clock requested and acknowledge high
  assert_exit_complete_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(lp_o) |-> (ack_o && need_clk_o));
endmodule

// File: rtl/lp_handshake_periph.sv
module lp_handshake_periph #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ctl_run_req,
  input  logic busy_i,
  input  logic wake_i,
  output logic need_clk_o,
  output logic periph_ack_o,
  output logic lp_state_o
);
  logic req_fall;
  logic req_rise;

  lp_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .req_i  (ctl_run_req),
    .fall_o (req_fall),
    .rise_o (req_rise)
  );

  lp_hs_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .fall_i     (req_fall),
    .rise_i     (req_rise),
    .busy_i     (busy_i),
    .wake_i     (wake_i),
    .need_clk_o (need_clk_o),
    .ack_o      (periph_ack_o),
    .lp_o       (lp_state_o)
  );

  // R1: the resting state has the acknowledge high
  assert_rest_ack_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> periph_ack_o);
endmodule

// File: tb/lp_handshake_periph_test.sv
module lp_handshake_periph_test;
  localparam int S   = 2;
  localparam int LAT = S + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b1;
  logic busy = 1'b0;
  logic wake = 1'b0;
  logic need_clk, ack, lp;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #2.5 clk = ~clk;

  lp_handshake_periph #(.SYNC_STAGES(S)) uut (
    .clk          (clk),
    .rst          (rst),
    .ctl_run_req  (req),
    .busy_i       (busy),
    .wake_i       (wake),
    .need_clk_o   (need_clk),
    .periph_ack_o (ack),
    .lp_state_o   (lp)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    step(3);
    chk("R1 ack in reset", ack, 1'b1);
    chk("R1 lp in reset", lp, 1'b0);
    chk("R1 need in reset", need_clk, 1'b0);
    rst = 1'b0;
    step(1);
    chk("R1 ack after reset", ack, 1'b1);
    chk("R1 lp after reset", lp, 1'b0);

    // R9: wake in run state has no effect
    wake = 1'b1;
    step(3);
    chk("R9 wake ignored in run", need_clk, 1'b0);
    wake = 1'b0;
    busy = 1'b1;
    step(1);
    chk("R2 need follows busy", need_clk, 1'b1);
    busy = 1'b0;
    step(1);
    chk("R2 need follows idle", need_clk, 1'b0);

    for (int b = 0; b < 2; b++) begin
      for (int m = 0; m < 3; m++) begin
        busy = logic'(b);
        wake = 1'b0;
        step(2);
        chk("R2 need equals busy", need_clk, logic'(b));
        req = 1'b0;
        step(LAT - 1);
        chk("R8 ack not early on request", ack, 1'b1);
        step(1);
        chk(b ? "R4 ack answers denial" : "R3 ack answers accept", ack, 1'b0);
        chk(b ? "R4 clock kept" : "R3 clock dropped", need_clk, logic'(b));
        chk(b ? "R4 lp stays 0" : "R3 lp set", lp, logic'(!b));
        if (b == 1) begin
          busy = 1'b0;
          step(3);
          chk("R4 clock held in denial", need_clk, 1'b1);
          chk("R4 lp 0 in denial", lp, 1'b0);
          req = 1'b1;
          step(LAT - 1);
          chk("R8 ack not early on release", ack, 1'b0);
          step(1);
          chk("R5 ack closes denial", ack, 1'b1);
          chk("R5 lp 0 after denial", lp, 1'b0);
        end else begin
          step(4);
          chk("R10 lp held", lp, 1'b1);
          chk("R10 need held low", need_clk, 1'b0);
          chk("R10 ack held low", ack, 1'b0);
          if (m == 0) begin
            req = 1'b1;
            step(LAT - 1);
            chk("R8 no early exit step", need_clk, 1'b0);
            step(1);
            chk("R6 clock requested", need_clk, 1'b1);
            chk("R6 ack still low", ack, 1'b0);
            chk("R6 lp still set", lp, 1'b1);
            step(1);
            chk("R6 ack completes exit", ack, 1'b1);
            chk("R6 lp cleared", lp, 1'b0);
          end else begin
            if (m == 1) wake = 1'b1;
            else        busy = 1'b1;
            step(1);
            chk("R7 clock requested locally", need_clk, 1'b1);
            step(3);
            chk("R7 ack waits for grant", ack, 1'b0);
            chk("R7 lp waits for grant", lp, 1'b1);
            wake = 1'b0;
            busy = 1'b0;
            req  = 1'b1;
            step(LAT - 1);
            chk("R8 ack not early on grant", ack, 1'b0);
            step(1);
            chk("R7 ack completes exit", ack, 1'b1);
            chk("R7 lp cleared", lp, 1'b0);
          end
        end
        step(2);
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule